// File: doc/BRIEF.md
# Keypad LED Brightness and Balance Modulator

This block produces the on/off gate for three keypad LED current sinks. Time is cut into repeating frames of `FRAME_TICKS` positions (192 by default), one position per cycle of a clock-enable tick. With a tick rate of 3.84 MHz, a frame lasts 50 µs, so it repeats at 20 kHz. A 3-bit brightness code picks a power-of-two fraction of the frame as the lit span. In overlapping mode, every enabled channel is lit during that span. In non-overlapping mode, the span is cut into consecutive slices, first channel 0, then channel 1, then channel 2. A 3-bit balance code sets the sizes of the slices.

The internal modulation can be bypassed, so that each channel simply follows its enable bit. A synchronized external PWM pin can also be routed to selected channels. When the internal modulation is bypassed, the pin replaces it. When the internal modulation is active, the pin gates it. The brightness, balance and overlap settings are captured only at a frame boundary, so a frame is never built from mixed settings.

Top module: `keypad_pwm_top`

## Requirements
- R1: The frame position starts at 0 after reset and advances by one on each cycle in which `frameTick` is high. After position `FRAME_TICKS-1` it wraps to 0. `chOn` is registered: it reflects the position and inputs of the previous clock and reads 0 during reset.
- R2: The lit span L, in positions, is 0 for brightness code 0. For codes 1 to 7, L is `FRAME_TICKS >> (7 - code)`, which gives 1/64, 1/32, 1/16, 1/8, 1/4, 1/2 and all of the frame.
- R3: In non-overlapping mode, channel 0, channel 1 and channel 2 occupy back-to-back slices starting at position 0. The slice lengths come from the balance code:
  - 0: L,0,0
  - 1: 0,L,0
  - 2: 0,0,L
  - 3: L/2,L/2,0
  - 4: 0,L/2,L/2
  - 5: L/2,0,L/2
  - 6: L/3,L/3,L/3
  - 7: L/2,L/4,L/4

  Divisions are rounded down. Every position after the last slice is dark, and at most one channel is lit at any position.
- R4: In overlapping mode (`overlapMode`=1), every enabled channel is lit at positions below L. The balance code has no effect in this mode.
- R5: With `kpEn`=1 and `intPwmEn`=0, each channel that takes no external PWM equals its `chEn` bit. Brightness, balance and overlap have no effect.
- R6: A channel with `extPinEn`=1, its `extSel` bit set and `intPwmEn`=0 follows the synchronized, active-high `extPwmIn`.
- R7: A channel with `extPinEn`=1, its `extSel` bit set and `intPwmEn`=1 is the AND of the internal modulation and the synchronized `extPwmIn`.
- R8: With `extPinEn`=0, `extPwmIn` and `extSel` have no effect on any output.
- R9: A channel is never lit unless both `kpEn` and its own `chEn` bit are high.
- R10: Brightness, balance and overlap written during a frame take effect only from position 0 of the next frame.
- R11: `extPwmIn` passes through two synchronizer flops, so a change on the pin reaches `chOn` three clocks later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameTick | input | 1 | Clock enable that advances the frame position |
| kpEn | input | 1 | Master keypad enable |
| intPwmEn | input | 1 | Select internal brightness/balance modulation |
| overlapMode | input | 1 | 1 = all channels share the lit span, 0 = sequential slices |
| brightCode | input | 3 | Logarithmic brightness code |
| balanceCode | input | 3 | Slice ratio code for non-overlapping mode |
| chEn | input | 3 | Per-channel enable |
| extSel | input | 3 | Per-channel routing of the external PWM pin |
| extPinEn | input | 1 | Honour the external PWM pin |
| extPwmIn | input | 1 | Asynchronous external PWM, active high |
| chOn | output | 3 | Per-channel LED on gate |

## Verification
The bench builds the block with its defaults: 192 positions per frame and a two-flop synchronizer. With 192 positions, every brightness code gives a whole number of positions. The 1/3 and 1/64 fractions are exact, and the rounding of the quarter shares at the lowest codes is exercised. With a two-flop synchronizer, the three-clock external latency can be checked at every cycle. Because a frame is only 192 cycles, all 64 brightness and balance pairs can be swept through full frames. Random tick gaps, mid-frame setting changes and random external toggling then land on every slice boundary and wrap.

// File: rtl/keypad_pwm_pkg.sv
package keypad_pwm_pkg;

  localparam int NUM_CH = 3;
  localparam int CODE_W = 3;

  typedef struct packed {
    logic [CODE_W-1:0] bright;
    logic [CODE_W-1:0] balance;
    logic              overlap;
  } kp_cfg_t;

  typedef struct packed {
    logic advance;
    logic wrap;
  } kp_strobe_t;

endpackage

// File: rtl/keypad_pwm_sync.sv
module keypad_pwm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/keypad_pwm_ctrl.sv
module keypad_pwm_ctrl
  import keypad_pwm_pkg::*;
#(
  parameter int FRAME_TICKS = 192,
  parameter int POS_W       = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameTick,
  output logic [POS_W-1:0] pos,
  output kp_strobe_t       strobe
);

  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_TICKS - 1);

  logic atLast;
  assign atLast = (pos == LAST_POS);

  always_comb begin
    strobe.advance = frameTick;
    strobe.wrap    = frameTick && atLast;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               pos <= '0;
    else if (strobe.wrap)    pos <= '0;
    else if (strobe.advance) pos <= pos + POS_W'(1);
  end

  // R1
  pos_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    pos <= LAST_POS);

  // R1
  wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameTick && pos == LAST_POS) |=> (pos == '0));

  // R1
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !frameTick |=> $stable(pos));

endmodule

// File: rtl/keypad_pwm_datapath.sv
module keypad_pwm_datapath
  import keypad_pwm_pkg::*;
#(
  parameter int FRAME_TICKS = 192,
  parameter int POS_W       = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  kp_strobe_t        strobe,
  input  logic [POS_W-1:0]  pos,
  input  kp_cfg_t           cfgIn,
  input  logic              kpEn,
  input  logic              intPwmEn,
  input  logic [NUM_CH-1:0] chEn,
  input  logic [NUM_CH-1:0] extSel,
  input  logic              extPinEn,
  input  logic              extSync,
  output logic [NUM_CH-1:0] chOn
);

  kp_cfg_t          cfgQ;
  logic [POS_W-1:0] spanLen;
  logic [POS_W-1:0] halfLen, thirdLen, quarterLen;
  logic [POS_W-1:0] sliceLen [NUM_CH];
  logic [POS_W-1:0] loB      [NUM_CH];
  logic [POS_W-1:0] hiB      [NUM_CH];
  logic [NUM_CH-1:0] slotOn;
  logic [NUM_CH-1:0] nextOn;

  // settings captured only at the frame wrap
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cfgQ <= '0;
    else if (strobe.wrap) cfgQ <= cfgIn;
  end

  // logarithmic span
  always_comb begin
    if (cfgQ.bright == '0) spanLen = '0;
    else spanLen = POS_W'(FRAME_TICKS >> (7 - int'(cfgQ.bright)));
    halfLen    = spanLen >> 1;
    thirdLen   = spanLen / POS_W'(3);
    quarterLen = spanLen >> 2;
  end

  // balance ratios
  always_comb begin
    sliceLen[0] = '0;
    sliceLen[1] = '0;
    sliceLen[2] = '0;
    case (cfgQ.balance)
      3'd0: sliceLen[0] = spanLen;
      3'd1: sliceLen[1] = spanLen;
      3'd2: sliceLen[2] = spanLen;
      3'd3: begin sliceLen[0] = halfLen; sliceLen[1] = halfLen; end
      3'd4: begin sliceLen[1] = halfLen; sliceLen[2] = halfLen; end
      3'd5: begin sliceLen[0] = halfLen; sliceLen[2] = halfLen; end
      3'd6: begin
        sliceLen[0] = thirdLen; sliceLen[1] = thirdLen; sliceLen[2] = thirdLen;
      end
      default: begin
        sliceLen[0] = halfLen; sliceLen[1] = quarterLen; sliceLen[2] = quarterLen;
      end
    endcase
  end

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic intOn;
      logic useExt;

      if (i == 0) begin : g_first
        assign loB[i] = '0;
      end else begin : g_next
        assign loB[i] = hiB[i-1];
      end
      assign hiB[i] = loB[i] + sliceLen[i];

      always_comb begin
        if (cfgQ.overlap) slotOn[i] = (pos < spanLen);
        else              slotOn[i] = (pos >= loB[i]) && (pos < hiB[i]);
        intOn     = intPwmEn ? slotOn[i] : 1'b1;
        useExt    = extPinEn && extSel[i];
        nextOn[i] = kpEn && chEn[i] && intOn && (!useExt || extSync);
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chOn <= '0;
    else       chOn <= nextOn;
  end

  // R9
  gate_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !kpEn |=> (chOn == '0));

  // R3
  slot_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgQ.overlap |-> $onehot0(slotOn));

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pos != '0) |-> $stable(cfgQ));

  // R2
  dark_chk: assert property (@(posedge clk) disable iff (!rstN)
    (intPwmEn && cfgQ.bright == '0) |=> (chOn == '0));

endmodule

// File: rtl/keypad_pwm_top.sv
module keypad_pwm_top
  import keypad_pwm_pkg::*;
#(
  parameter int FRAME_TICKS = 192,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameTick,
  input  logic              kpEn,
  input  logic              intPwmEn,
  input  logic              overlapMode,
  input  logic [CODE_W-1:0] brightCode,
  input  logic [CODE_W-1:0] balanceCode,
  input  logic [NUM_CH-1:0] chEn,
  input  logic [NUM_CH-1:0] extSel,
  input  logic              extPinEn,
  input  logic              extPwmIn,
  output logic [NUM_CH-1:0] chOn
);

  localparam int POS_W = $clog2(FRAME_TICKS + 1);

  logic [POS_W-1:0] pos;
  kp_strobe_t       strobe;
  kp_cfg_t          cfgIn;
  logic             extSync;

  assign cfgIn = '{bright: brightCode, balance: balanceCode, overlap: overlapMode};

  keypad_pwm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .din(extPwmIn), .dout(extSync)
  );

  keypad_pwm_ctrl #(.FRAME_TICKS(FRAME_TICKS), .POS_W(POS_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .frameTick(frameTick), .pos(pos), .strobe(strobe)
  );

  keypad_pwm_datapath #(.FRAME_TICKS(FRAME_TICKS), .POS_W(POS_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pos(pos), .cfgIn(cfgIn),
    .kpEn(kpEn), .intPwmEn(intPwmEn), .chEn(chEn), .extSel(extSel),
    .extPinEn(extPinEn), .extSync(extSync), .chOn(chOn)
  );

endmodule

// File: tb/keypad_pwm_top_tb.sv
module keypad_pwm_top_tb;

  localparam int FRAME = 192;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameTick = 1'b1;
  logic kpEn = 1'b0, intPwmEn = 1'b0, overlapMode = 1'b0;
  logic [2:0] brightCode = '0, balanceCode = '0, chEn = '0, extSel = '0;
  logic extPinEn = 1'b0, extPwmIn = 1'b0;
  logic [2:0] chOn;

  int nChecks = 0, nFails = 0, cycles = 0;
  bit checking = 0, extToggle = 0, tickRandom = 0;
  string curTag = "R1";

  // bench reference state
  int mPos = 0;
  int mBr = 0, mBal = 0;
  bit mOv = 0, s1 = 0, s2 = 0;
  logic [2:0] expOn = '0;

  always #10 clk = ~clk;

  keypad_pwm_top u_dut (
    .clk(clk), .rstN(rstN), .frameTick(frameTick), .kpEn(kpEn),
    .intPwmEn(intPwmEn), .overlapMode(overlapMode), .brightCode(brightCode),
    .balanceCode(balanceCode), .chEn(chEn), .extSel(extSel),
    .extPinEn(extPinEn), .extPwmIn(extPwmIn), .chOn(chOn)
  );

  function automatic logic [2:0] expectOn(int p, int br, int bal, bit ov, bit kp,
      bit ip, logic [2:0] en, logic [2:0] sel, bit pinEn, bit ex);
    int span;
    int len [3];
    int lo, hi;
    logic [2:0] r;
    span = (br == 0) ? 0 : (FRAME >> (7 - br));
    len[0] = 0; len[1] = 0; len[2] = 0;
    case (bal)
      0: len[0] = span;
      1: len[1] = span;
      2: len[2] = span;
      3: begin len[0] = span/2; len[1] = span/2; end
      4: begin len[1] = span/2; len[2] = span/2; end
      5: begin len[0] = span/2; len[2] = span/2; end
      6: begin len[0] = span/3; len[1] = span/3; len[2] = span/3; end
      default: begin len[0] = span/2; len[1] = span/4; len[2] = span/4; end
    endcase
    lo = 0;
    for (int i = 0; i < 3; i++) begin
      bit inside_slot;
      bit internal;
      hi = lo + len[i];
      inside_slot = ov ? (p < span) : (p >= lo && p < hi);
      internal = ip ? inside_slot : 1'b1;
      r[i] = kp && en[i] && internal && !(pinEn && sel[i] && !ex);
      lo = hi;
    end
    return r;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPos = 0; mBr = 0; mBal = 0; mOv = 0; s1 = 0; s2 = 0; expOn = '0;
    end else begin
      expOn = expectOn(mPos, mBr, mBal, mOv, kpEn, intPwmEn, chEn, extSel,
                       extPinEn, s2);
      s2 = s1;
      s1 = extPwmIn;
      if (frameTick) begin
        if (mPos == FRAME - 1) begin
          mPos = 0; mBr = int'(brightCode); mBal = int'(balanceCode); mOv = overlapMode;
        end else mPos = mPos + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (extToggle) extPwmIn <= 1'($urandom % 2);
    frameTick <= tickRandom ? 1'($urandom % 2) : 1'b1;
    if (checking && rstN) begin
      nChecks++;
      if (chOn !== expOn) begin
        nFails++;
        $display("FAIL %s chOn actual=%b expected=%b at pos=%0d", curTag, chOn, expOn, mPos);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      nFails++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
      $finish;
    end
  end

  task automatic runCycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setCfg(int br, int bal, bit ov);
    brightCode = 3'(br); balanceCode = 3'(bal); overlapMode = ov;
  endtask

  function automatic string tagFor();
    if (!kpEn || chEn != 3'b111) return "R9";
    if (!extPinEn && extSel != 0) return "R8";
    if (extPinEn && extSel != 0) return intPwmEn ? "R7" : "R6";
    if (!intPwmEn) return "R5";
    return overlapMode ? "R4" : "R3";
  endfunction

  initial begin
    void'($urandom(32'h5EED1));
    // reset state
    repeat (3) begin
      @(negedge clk);
      nChecks++;
      if (chOn !== 3'b000) begin
        nFails++;
        $display("FAIL R1 reset chOn actual=%b expected=000", chOn);
      end
    end
    kpEn = 1; intPwmEn = 1; chEn = 3'b111; setCfg(7, 0, 0);
    @(negedge clk); rstN = 1; checking = 1;

    // brightness and balance sweep
    curTag = "R2 R3";
    for (int bal = 0; bal < 8; bal++) begin
      for (int br = 0; br < 8; br++) begin
        setCfg(br, bal, 0);
        runCycles(2 * FRAME + 3);
      end
    end

    // overlapping mode, balance ignored
    curTag = "R4";
    for (int br = 0; br < 8; br++) begin
      setCfg(br, int'($urandom % 8), 1);
      runCycles(2 * FRAME);
    end

    // mid-frame changes and irregular ticks
    curTag = "R10";
    setCfg(7, 6, 0);
    runCycles(FRAME + 40);
    setCfg(6, 7, 1);
    runCycles(30);
    setCfg(5, 3, 0);
    runCycles(2 * FRAME);
    curTag = "R1";
    tickRandom = 1;
    runCycles(5 * FRAME);
    tickRandom = 0;

    // direct on/off mode
    curTag = "R5";
    intPwmEn = 0;
    repeat (20) begin
      chEn = 3'($urandom % 8);
      setCfg(int'($urandom % 8), int'($urandom % 8), 1'($urandom % 2));
      runCycles(50);
    end
    chEn = 3'b111;

    // external pin replacing internal modulation
    curTag = "R6 R11";
    extPinEn = 1; extToggle = 1;
    repeat (10) begin
      extSel = 3'($urandom % 8);
      runCycles(100);
    end

    // external pin gating internal modulation
    curTag = "R7";
    intPwmEn = 1;
    setCfg(7, 6, 0);
    repeat (8) begin
      extSel = 3'($urandom % 8);
      runCycles(FRAME);
    end

    // pin disabled: ignored
    curTag = "R8";
    extPinEn = 0; extSel = 3'b111;
    runCycles(2 * FRAME);
    intPwmEn = 0;
    runCycles(100);

    // master and channel enables
    curTag = "R9";
    intPwmEn = 1; setCfg(7, 0, 1);
    kpEn = 0; runCycles(FRAME);
    kpEn = 1; chEn = 3'b010; runCycles(FRAME);
    chEn = 3'b111;

    // constrained random
    repeat (110) begin
      kpEn = ($urandom % 8) != 0;
      intPwmEn = 1'($urandom % 2);
      chEn = (($urandom % 4) == 0) ? 3'($urandom % 8) : 3'b111;
      extPinEn = 1'($urandom % 2);
      extSel = 3'($urandom % 8);
      extToggle = 1'($urandom % 2);
      tickRandom = ($urandom % 4) == 0;
      setCfg(int'($urandom % 8), int'($urandom % 8), 1'($urandom % 2));
      curTag = tagFor();
      runCycles(150 + int'($urandom % 300));
    end

    checking = 0;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end

endmodule